// File: doc/BRIEF.md
# Auto-masking interrupt event controller

This block collects a set of level-sensitive interrupt lines and hands them to a small group of processors. Each line can be masked, raised by software, and routed to processors through a per-line bitmap. A line is pending while its hardware input or its software-trigger bit is high. Each processor has an interrupt output that stays high while at least one pending, unmasked line is routed to it.

A processor services interrupts by reading its event register. The read returns the lowest-numbered line that is pending, unmasked and routed to the reading processor. It tags that value with a hardware source type, and it masks the reported line in the same access. The handler then drains the register until it reads zero. It re-enables each serviced line by writing that line's bit to the mask-clear register.

All state is reached through a 32-bit register port. A processor-select input tells the block which processor is making the access. Read data appears one cycle after the read.

Top module: `automask_intc`

## Requirements
- R1: After reset every line is masked, every software-trigger bit is clear, every target register reads 1 (routed to processor 0) and all interrupt outputs are low.
- R2: A read of address 0x000 returns the number of lines in bits 15:0 and zero in bits 31:16.
- R3: Mask bits are written through a set register at 0x900 and a clear register at 0x980, one 32-bit word every 4 bytes. Line x is word x/32, bit x%32. A 1 sets or clears that bit, a 0 leaves it unchanged, and reading either address returns the mask word.
- R4: Software-trigger bits use the same word layout and write rules, with set at 0x800 and clear at 0x880. A line is pending when its hardware input or its trigger bit is 1.
- R5: The target register of line n sits at 0x400 + 4n. Its bit c routes the line to processor c, and it reads back as written. Accesses above the last line read 0 and are ignored on write.
- R6: interrupt output c is high in the same cycle as the state change if and only if some line is pending, unmasked and has target bit c set.
- R7: A read of the event register at 0x004 by processor c returns, on the next cycle, type 1 in bits 31:16 and in bits 15:0 the lowest-numbered line that is pending, unmasked and routed to c.
- R8: The event read that reports a line sets that line's mask bit, and the bit is visible from the next cycle.
- R9: An event read with no eligible line returns 0 and changes no state.
- R10: Lines routed only to other processors are neither reported by, nor masked by, an event read of processor c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hw_irq | input | NUM_LINES | Level-sensitive interrupt inputs |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_cpu | input | CPU_W | Index of the accessing processor |
| bus_rdata | output | 32 | Read data, one cycle after the read, 0 otherwise |
| irq_o | output | NUM_CPUS | Per-processor interrupt request |

## Verification
The bench builds the block with 40 lines and 3 processors. With 40 lines the second mask and trigger words are only partly populated, so line 39 sits at word 1, bit 7, and a target access to line 40 lands just past the end. With 3 processors, routing can send lines to a processor other than the default one, which shows that processors do not interfere with each other. Line 0 is also exercised, because its event word differs from the empty value only in its type field.

// File: rtl/automask_intc.sv
module automask_intc #(
  parameter int NUM_LINES = 64,
  parameter int NUM_CPUS  = 4,
  localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] hw_irq,
  input  logic                 bus_en,
  input  logic                 bus_we,
  input  logic [11:0]          bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic [CPU_W-1:0]     bus_cpu,
  output logic [31:0]          bus_rdata,
  output logic [NUM_CPUS-1:0]  irq_o
);
  localparam int NW = (NUM_LINES + 31) / 32;
  localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam logic [4:0] G_SWSET = 5'h10;
  localparam logic [4:0] G_SWCLR = 5'h11;
  localparam logic [4:0] G_MSET  = 5'h12;
  localparam logic [4:0] G_MCLR  = 5'h13;
  localparam logic [11:0] A_INFO  = 12'h000;
  localparam logic [11:0] A_EVENT = 12'h004;

  logic wr, rd, aligned, is_tgt, cpu_ok;
  logic [4:0] grp, widx;
  logic [7:0] tline;

  assign wr      = bus_en & bus_we;
  assign rd      = bus_en & ~bus_we;
  assign aligned = bus_addr[1:0] == 2'b00;
  assign grp     = bus_addr[11:7];
  assign widx    = bus_addr[6:2];
  assign tline   = bus_addr[9:2];
  assign is_tgt  = aligned && bus_addr[11:10] == 2'b01;
  assign cpu_ok  = 32'(bus_cpu) < NUM_CPUS;

  logic [NUM_LINES-1:0] mask_q, sw_q, pend;
  logic [NUM_LINES-1:0][NUM_CPUS-1:0] tgt;
  logic [NUM_LINES-1:0] sel_vec;
  logic                 found, ev_take;
  logic [LW-1:0]        ev_line;

  assign pend = (hw_irq | sw_q) & ~mask_q;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam int W = i / 32;
    localparam int B = i % 32;
    logic m_q, s_q, hit;
    logic [NUM_CPUS-1:0] t_q;

    assign hit = aligned && widx == 5'(W) && bus_wdata[B];

    always_ff @(posedge clk) begin
      if (rst) begin
        m_q <= 1'b1;
        s_q <= 1'b0;
        t_q <= NUM_CPUS'(1);
      end else begin
        if (wr && hit && grp == G_MSET)                   m_q <= 1'b1;
        else if (wr && hit && grp == G_MCLR)              m_q <= 1'b0;
        else if (ev_take && ev_line == LW'(i))            m_q <= 1'b1;
        if (wr && hit && grp == G_SWSET)                  s_q <= 1'b1;
        else if (wr && hit && grp == G_SWCLR)             s_q <= 1'b0;
        if (wr && is_tgt && tline == 8'(i))               t_q <= bus_wdata[NUM_CPUS-1:0];
      end
    end

    assign mask_q[i]  = m_q;
    assign sw_q[i]    = s_q;
    assign tgt[i]     = t_q;
    assign sel_vec[i] = pend[i] & cpu_ok & t_q[bus_cpu];
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic [NUM_LINES-1:0] route;
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_r
      assign route[i] = tgt[i][c];
    end
    assign irq_o[c] = |(pend & route);
  end

  always_comb begin
    found   = 1'b0;
    ev_line = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (sel_vec[i]) begin
        found   = 1'b1;
        ev_line = LW'(i);
      end
    end
  end

  assign ev_take = rd && bus_addr == A_EVENT && found;

  logic [NW*32-1:0] mask_pad, sw_pad;
  assign mask_pad = (NW*32)'(mask_q);
  assign sw_pad   = (NW*32)'(sw_q);

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_INFO) begin
      rd_mux = {16'd0, 16'(NUM_LINES)};
    end else if (bus_addr == A_EVENT) begin
      if (found) rd_mux = {16'd1, 16'(ev_line)};
    end else if (is_tgt) begin
      if (32'(tline) < NUM_LINES) rd_mux = 32'(tgt[LW'(tline)]);
    end else if (aligned && 32'(widx) < NW) begin
      if (grp == G_MSET || grp == G_MCLR)        rd_mux = mask_pad[32*int'(widx) +: 32];
      else if (grp == G_SWSET || grp == G_SWCLR) rd_mux = sw_pad[32*int'(widx) +: 32];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd ? rd_mux : '0;
  end
endmodule

// File: rtl/automask_intc_chk.sv
module automask_intc_chk #(
  parameter int NUM_LINES = 64,
  parameter int NUM_CPUS  = 4,
  localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int LW       = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_en,
  input logic                 bus_we,
  input logic [11:0]          bus_addr,
  input logic [CPU_W-1:0]     bus_cpu,
  input logic [31:0]          bus_rdata,
  input logic [NUM_CPUS-1:0]  irq_o,
  input logic [NUM_LINES-1:0] mask_q
);
  logic ev_rd, cpu_irq;
  assign ev_rd   = bus_en && !bus_we && bus_addr == 12'h004 && 32'(bus_cpu) < NUM_CPUS;
  assign cpu_irq = (32'(bus_cpu) < NUM_CPUS) ? irq_o[bus_cpu] : 1'b0;

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> irq_o == '0);

  assert_irq_needs_unmasked_R6: assert property (@(posedge clk) disable iff (rst)
    (|irq_o) |-> !(&mask_q));

  assert_event_type_R7: assert property (@(posedge clk) disable iff (rst)
    ev_rd && cpu_irq |=> bus_rdata[31:16] == 16'd1 && 32'(bus_rdata[15:0]) < NUM_LINES);

  assert_event_masks_R8: assert property (@(posedge clk) disable iff (rst)
    ev_rd && cpu_irq |=> mask_q[bus_rdata[LW-1:0]]);

  assert_empty_zero_R9: assert property (@(posedge clk) disable iff (rst)
    ev_rd && !cpu_irq |=> bus_rdata == 32'd0);
endmodule

bind automask_intc automask_intc_chk #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS)) u_chk (
  .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_cpu(bus_cpu), .bus_rdata(bus_rdata), .irq_o(irq_o), .mask_q(mask_q)
);

// File: tb/automask_intc_test.sv
module automask_intc_test;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 40;
  localparam int NC = 3;

  logic clk = 0;
  logic rst = 1;
  logic [NL-1:0] hw_irq = '0;
  logic bus_en = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [1:0] bus_cpu = '0;
  logic [31:0] bus_rdata;
  logic [NC-1:0] irq_o;

  int vectors = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  automask_intc #(.NUM_LINES(NL), .NUM_CPUS(NC)) uut (
    .clk(clk), .rst(rst), .hw_irq(hw_irq), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_cpu(bus_cpu),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [1:0] cpu, output logic [31:0] d);
    bus_en = 1; bus_we = 0; bus_addr = a; bus_cpu = cpu;
    @(negedge clk);
    d = bus_rdata;
    bus_en = 0;
  endtask

  task automatic t_reset_r1_r2();
    logic [31:0] d;
    check("R1 irq", 32'(irq_o), 0);
    rd(12'h900, 0, d); check("R1 mask w0", d, 32'hFFFF_FFFF);
    rd(12'h984, 0, d); check("R1 mask w1", d, 32'h0000_00FF);
    rd(12'h800, 0, d); check("R1 sw w0", d, 0);
    rd(12'h400, 0, d); check("R1 tgt0", d, 1);
    rd(12'h49C, 0, d); check("R1 tgt39", d, 1);
    rd(12'h000, 0, d); check("R2 info", d, NL);
  endtask

  task automatic t_mask_r3();
    logic [31:0] d;
    wr(12'h980, 32'h5);   rd(12'h900, 0, d); check("R3 clr", d, 32'hFFFF_FFFA);
    wr(12'h900, 32'h1);   rd(12'h980, 0, d); check("R3 set", d, 32'hFFFF_FFFB);
    wr(12'h980, 32'h0);   rd(12'h900, 0, d); check("R3 zero no effect", d, 32'hFFFF_FFFB);
    wr(12'h984, 32'hFFFF_FF80); rd(12'h904, 0, d); check("R3 line39 word1 bit7", d, 32'h7F);
  endtask

  task automatic t_sw_r4();
    logic [31:0] d;
    wr(12'h804, 32'h80); rd(12'h884, 0, d); check("R4 sw set", d, 32'h80);
    check("R4 sw pending irq", 32'(irq_o), 32'b001);
    wr(12'h884, 32'h0); rd(12'h804, 0, d); check("R4 sw clr zero no effect", d, 32'h80);
    wr(12'h884, 32'h80); check("R4 sw cleared irq", 32'(irq_o), 0);
    hw_irq[2] = 1; #1; check("R4 hw pending", 32'(irq_o), 32'b001);
    hw_irq[2] = 0; #1; check("R4 hw low", 32'(irq_o), 0);
  endtask

  task automatic t_target_r5_r6();
    logic [31:0] d;
    wr(12'h408, 32'h4); rd(12'h408, 0, d); check("R5 tgt2 readback", d, 32'h4);
    wr(12'h4A0, 32'h2); rd(12'h4A0, 0, d); check("R5 beyond last line", d, 0);
    hw_irq[2] = 1; #1; check("R6 routed to cpu2", 32'(irq_o), 32'b100);
    hw_irq[3] = 1; #1; check("R6 masked line ignored", 32'(irq_o), 32'b100);
    hw_irq[3] = 0;
  endtask

  task automatic t_priority_r7_r8_r9_r10();
    logic [31:0] d;
    wr(12'h980, 32'h420);
    wr(12'h414, 32'h4);
    wr(12'h428, 32'h4);
    hw_irq[5] = 1; hw_irq[10] = 1;
    rd(12'h004, 0, d); check("R10 cpu0 sees none", d, 0);
    rd(12'h900, 0, d); check("R9 no state change", d, 32'hFFFF_FBDB);
    rd(12'h004, 2, d); check("R7 first line2", d, 32'h0001_0002);
    rd(12'h004, 2, d); check("R7 then line5", d, 32'h0001_0005);
    rd(12'h004, 2, d); check("R7 then line10", d, 32'h0001_000A);
    rd(12'h004, 2, d); check("R9 drained", d, 0);
    rd(12'h900, 0, d); check("R8 lines masked", d, 32'hFFFF_FFFF);
    check("R8 irq dropped", 32'(irq_o), 0);
  endtask

  task automatic t_cross_cpu_r10();
    logic [31:0] d;
    wr(12'h49C, 32'h2);
    wr(12'h804, 32'h80);
    check("R6 cpu1 irq", 32'(irq_o), 32'b010);
    rd(12'h004, 0, d); check("R10 cpu0 none", d, 0);
    rd(12'h904, 0, d); check("R10 line39 still unmasked", d, 32'h7F);
    rd(12'h004, 1, d); check("R7 cpu1 line39", d, 32'h0001_0027);
    rd(12'h904, 0, d); check("R8 line39 masked", d, 32'hFF);
  endtask

  task automatic t_line0_r7();
    logic [31:0] d;
    hw_irq[0] = 1;
    wr(12'h980, 32'h1); check("R6 line0 irq", 32'(irq_o), 32'b001);
    rd(12'h004, 0, d); check("R7 line0 word", d, 32'h0001_0000);
    check("R8 line0 irq off", 32'(irq_o), 0);
    wr(12'h980, 32'h1); check("R6 level reasserts", 32'(irq_o), 32'b001);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset_r1_r2();
        t_mask_r3();
        t_sw_r4();
        t_target_r5_r6();
        t_priority_r7_r8_r9_r10();
        t_cross_cpu_r10();
        t_line0_r7();
      end
      begin
        repeat (5000) @(posedge clk);
        vectors++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule